// File: doc/BRIEF.md
# Audio Transmit Sample Packer

This block sits between a host-side register write path and a serial audio codec link. Every host write carries a 32-bit word. The block turns that word into one or two 20-bit, left-aligned samples and queues them in a circular buffer. When the transmit path is switched on and at least one audio slot is selected, the block hands buffered samples to the link sink as left/right pairs. A small controller decides when draining may begin, and four status flags tell the host how full the buffer is.

Samples narrower than 20 bits are widened by shifting them toward the most significant end. In packed mode one write carries two 16-bit halves, and the lower half is queued first. Packed mode only has meaning for 12-bit and 16-bit samples. A write that does not fit is dropped.

Draining is controlled by a two-state machine:
- `ST_IDLE` waits until transmit is enabled, a slot is selected and the buffer is at least half full. Transition `start_burst` then moves it to `ST_DRAIN`.
- `ST_DRAIN` offers a pair whenever two or more samples are buffered. Transition `end_burst` returns it to `ST_IDLE` in any cycle where no pair is taken. That happens when the sink refuses, when fewer than two samples remain, or when transmit is disabled.

Top module: `tx_fifo_packer`

## Requirements
- R1: In unpacked mode each accepted write stores one sample. The 2-bit size code selects the widening: code 3 is 12-bit (bits 11:0 shifted left 8), code 0 is 16-bit (bits 15:0 shifted left 4), code 1 is 18-bit (bits 17:0 shifted left 2), code 2 is 20-bit (bits 19:0 unchanged). Bits above each field are discarded.
- R2: In packed mode with size code 0 or 3, one write stores two samples. The first is bits 15:0 and the second is bits 31:16, each widened as in R1.
- R3: With size code 1 or 2 the packed-mode request is ignored, and the write stores a single sample exactly as in R1.
- R4: An unpacked write is accepted only while level < DEPTH. A packed write is accepted only while level + 2 < DEPTH. A refused write changes neither the buffer nor the flags.
- R5: An accepted write clears the empty and underrun flags. A drain that leaves the buffer at zero sets both flags. Underrun is never set except by such a drain.
- R6: An accepted write clears the half-empty flag when the resulting level is at least DEPTH/2. Any drain that leaves level at or below DEPTH/2 sets it.
- R7: An accepted write that brings level to DEPTH sets the full flag. Any drain clears it.
- R8: A pair is offered only when transmit is enabled and slot_sel is nonzero. A burst starts only at level ≥ DEPTH/2, so below that level nothing is offered.
- R9: Pairs leave in write order: the older sample goes on the left lane. A burst keeps going while the sink accepts and two or more samples remain. After a refusal the next burst starts only if level is still ≥ DEPTH/2.
- R10: After reset the buffer is empty, empty and half-empty are set, full and underrun are clear, and no pair is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| size_sel | input | 2 | Sample size code (0=16, 1=18, 2=20, 3=12 bits) |
| compact_req | input | 1 | Request packed two-sample writes |
| tx_enable | input | 1 | Transmit enable |
| slot_sel | input | 2 | Audio slot selection; any set bit allows draining |
| pair_ready | input | 1 | Sink accepts the offered pair |
| pair_valid | output | 1 | A left/right pair is offered |
| pair_left | output | 20 | Older sample of the pair |
| pair_right | output | 20 | Newer sample of the pair |
| flag_empty | output | 1 | Buffer empty |
| flag_half | output | 1 | Half-empty status (with hysteresis at DEPTH/2) |
| flag_full | output | 1 | Buffer full |
| flag_underrun | output | 1 | Buffer drained to empty |

## Verification
The bound checker watches several relations on every cycle:
- a pair is never offered without enable and a selected slot;
- a pair is never offered while the buffer is empty;
- full excludes both half-empty and empty;
- underrun implies empty;
- underrun rises only after an accepted pair, and full rises only after a write.

The widening and ordering of stored samples, the write-acceptance thresholds and the exact flag values after each write and burst can only be shown by the bench. It compares every drained pair and every flag state against a reference queue it keeps itself.

// File: rtl/tfp_pkg.sv
package tfp_pkg;

    localparam int SAMPLE_W = 20;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_18 = 2'd1,
        SZ_20 = 2'd2,
        SZ_12 = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } drain_state_e;

    // Left-align a sample of the selected width into SAMPLE_W bits.
    function automatic logic [SAMPLE_W-1:0] widen(input logic [WORD_W-1:0] v, input size_e sz);
        logic [SAMPLE_W-1:0] r;
        unique case (sz)
            SZ_12: r = {v[11:0], 8'b0};
            SZ_16: r = {v[15:0], 4'b0};
            SZ_18: r = {v[17:0], 2'b0};
            SZ_20: r = v[SAMPLE_W-1:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tfp_unpack.sv
module tfp_unpack
    import tfp_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    input  size_e               size,
    input  logic                compact_req,
    output logic [SAMPLE_W-1:0] samp0,
    output logic [SAMPLE_W-1:0] samp1,
    output logic                two
);
    localparam int LANES = WORD_W / HALF_W;

    logic [SAMPLE_W-1:0] lane_w [LANES];
    logic                compact_eff;

    // Packed writes only make sense for the two narrow sizes.
    assign compact_eff = compact_req && (size == SZ_16 || size == SZ_12);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_w[l] = widen({{(WORD_W-HALF_W){1'b0}}, word[l*HALF_W +: HALF_W]}, size);
    end

    assign samp0 = compact_eff ? lane_w[0] : widen(word, size);
    assign samp1 = lane_w[1];
    assign two   = compact_eff;

endmodule

// File: rtl/tfp_ring.sv
module tfp_ring #(
    parameter  int DEPTH = 8,
    parameter  int WIDTH = 20,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             wr_two,
    input  logic [WIDTH-1:0] d0,
    input  logic [WIDTH-1:0] d1,
    input  logic             pop,
    output logic             wr_ok,
    output logic [WIDTH-1:0] head0,
    output logic [WIDTH-1:0] head1,
    output logic [LW-1:0]    level,
    output logic [LW-1:0]    lvl_push,
    output logic [LW-1:0]    lvl_next
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [LW-1:0]    level_q;
    logic [LW-1:0]    add_n;

    always_comb begin
        if (wr_two) begin
            wr_ok = wr_req && (level_q < LW'(DEPTH - 2));
        end else begin
            wr_ok = wr_req && (level_q < LW'(DEPTH));
        end
        add_n    = wr_ok ? (wr_two ? LW'(2) : LW'(1)) : '0;
        lvl_push = level_q + add_n;
        lvl_next = lvl_push - (pop ? LW'(2) : '0);
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= d0;
            if (wr_two) begin
                mem[wr_ptr + AW'(1)] <= d1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= wr_ptr + (wr_two ? AW'(2) : AW'(1));
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(2);
            end
            level_q <= lvl_next;
        end
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr + AW'(1)];
    assign level = level_q;

endmodule

// File: rtl/tfp_flags.sv
module tfp_flags #(
    parameter  int DEPTH = 8,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pushed,
    input  logic [LW-1:0] lvl_push,
    input  logic          popped,
    input  logic [LW-1:0] lvl_final,
    output logic          empty,
    output logic          half,
    output logic          full,
    output logic          underrun
);
    localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH / 2);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic empty_n, half_n, full_n, und_n;

    // Write rules first, then drain rules, matching the event order.
    always_comb begin
        empty_n = empty;
        half_n  = half;
        full_n  = full;
        und_n   = underrun;
        if (pushed) begin
            empty_n = 1'b0;
            und_n   = 1'b0;
            if (lvl_push >= HALF_LVL) half_n = 1'b0;
            if (lvl_push >= FULL_LVL) full_n = 1'b1;
        end
        if (popped) begin
            full_n = 1'b0;
            if (lvl_final <= HALF_LVL) half_n = 1'b1;
            if (lvl_final == '0) begin
                empty_n = 1'b1;
                und_n   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty    <= 1'b1;
            half     <= 1'b1;
            full     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            empty    <= empty_n;
            half     <= half_n;
            full     <= full_n;
            underrun <= und_n;
        end
    end

endmodule

// File: rtl/tx_fifo_packer.sv
module tx_fifo_packer
    import tfp_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int LW    = $clog2(DEPTH) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [1:0]          size_sel,
    input  logic                compact_req,
    input  logic                tx_enable,
    input  logic [1:0]          slot_sel,
    input  logic                pair_ready,
    output logic                pair_valid,
    output logic [SAMPLE_W-1:0] pair_left,
    output logic [SAMPLE_W-1:0] pair_right,
    output logic                flag_empty,
    output logic                flag_half,
    output logic                flag_full,
    output logic                flag_underrun
);
    if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
        $error("DEPTH must be a power of two of at least 4");
    end

    localparam logic [LW-1:0] START_LVL = LW'(DEPTH / 2);

    drain_state_e        state_q, state_n;
    logic [SAMPLE_W-1:0] s0, s1;
    logic                two, wr_ok, pop, drain_ok;
    logic [LW-1:0]       level, lvl_push, lvl_next;

    tfp_unpack u_unpack (
        .word        (wr_data),
        .size        (size_e'(size_sel)),
        .compact_req (compact_req),
        .samp0       (s0),
        .samp1       (s1),
        .two         (two)
    );

    tfp_ring #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_en),
        .wr_two   (two),
        .d0       (s0),
        .d1       (s1),
        .pop      (pop),
        .wr_ok    (wr_ok),
        .head0    (pair_left),
        .head1    (pair_right),
        .level    (level),
        .lvl_push (lvl_push),
        .lvl_next (lvl_next)
    );

    tfp_flags #(.DEPTH(DEPTH)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .pushed    (wr_ok),
        .lvl_push  (lvl_push),
        .popped    (pop),
        .lvl_final (lvl_next),
        .empty     (flag_empty),
        .half      (flag_half),
        .full      (flag_full),
        .underrun  (flag_underrun)
    );

    assign drain_ok = tx_enable && (slot_sel != 2'b00);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next state: start_burst / end_burst
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (drain_ok && level >= START_LVL) state_n = ST_DRAIN;
            ST_DRAIN: if (!pop)                           state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pair_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  pair_valid = 1'b0;
            ST_DRAIN: pair_valid = drain_ok && (level >= LW'(2));
        endcase
        pop = pair_valid && pair_ready;
    end

endmodule

// File: rtl/tfp_checker.sv
module tfp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       tx_enable,
    input logic [1:0] slot_sel,
    input logic       pair_valid,
    input logic       pair_ready,
    input logic       flag_empty,
    input logic       flag_half,
    input logic       flag_full,
    input logic       flag_underrun
);
    p_drain_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (tx_enable && slot_sel != 2'b00));

    p_no_pair_when_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_empty |-> !pair_valid);

    p_full_excludes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_full |-> (!flag_half && !flag_empty));

    p_underrun_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underrun |-> flag_empty);

    p_underrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_underrun) |-> $past(pair_valid && pair_ready));

    p_full_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_full) |-> $past(wr_en));

    p_empty_clear_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_empty) |-> $past(wr_en));

endmodule

bind tx_fifo_packer tfp_checker i_tfp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .tx_enable     (tx_enable),
    .slot_sel      (slot_sel),
    .pair_valid    (pair_valid),
    .pair_ready    (pair_ready),
    .flag_empty    (flag_empty),
    .flag_half     (flag_half),
    .flag_full     (flag_full),
    .flag_underrun (flag_underrun)
);

// File: tb/test_tx_fifo_packer.sv
`timescale 1ns/1ps
module test_tx_fifo_packer;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  size_sel = '0;
    logic        compact_req = 1'b0;
    logic        tx_enable = 1'b0;
    logic [1:0]  slot_sel = '0;
    logic        pair_ready = 1'b0;
    logic        pair_valid;
    logic [19:0] pair_left, pair_right;
    logic        flag_empty, flag_half, flag_full, flag_underrun;

    int errors = 0;
    int checks = 0;
    int q[$];
    bit e_empty = 1, e_half = 1, e_full = 0, e_und = 0;

    always #2.5 clk = ~clk;

    tx_fifo_packer #(.DEPTH(D)) i_tx_fifo_packer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .size_sel(size_sel), .compact_req(compact_req), .tx_enable(tx_enable),
        .slot_sel(slot_sel), .pair_ready(pair_ready), .pair_valid(pair_valid),
        .pair_left(pair_left), .pair_right(pair_right), .flag_empty(flag_empty),
        .flag_half(flag_half), .flag_full(flag_full), .flag_underrun(flag_underrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_widen(input int v, input int sz);
        case (sz)
            0: return (v << 4) & 'hFFFFF;
            1: return (v << 2) & 'hFFFFF;
            2: return v & 'hFFFFF;
            default: return (v << 8) & 'hFFFFF;
        endcase
    endfunction

    task automatic check_flags(input string req);
        chk(req, "empty", int'(flag_empty), int'(e_empty));
        chk(req, "half", int'(flag_half), int'(e_half));
        chk(req, "full", int'(flag_full), int'(e_full));
        chk(req, "underrun", int'(flag_underrun), int'(e_und));
    endtask

    task automatic do_write(input logic [31:0] data, input int sz, input bit cmp, input string req);
        bit packed_w;
        bit ok;
        @(negedge clk);
        wr_en = 1'b1; wr_data = data; size_sel = 2'(sz); compact_req = cmp;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        packed_w = cmp && (sz == 0 || sz == 3);
        ok = packed_w ? (q.size() + 2 < D) : (q.size() < D);
        if (ok) begin
            if (packed_w) begin
                q.push_back(exp_widen(int'(data[15:0]), sz));
                q.push_back(exp_widen(int'(data[31:16]), sz));
            end else begin
                q.push_back(exp_widen(int'(data), sz));
            end
            e_empty = 0; e_und = 0;
            if (q.size() >= D/2) e_half = 0;
            if (q.size() >= D) e_full = 1;
        end
        check_flags(req);
    endtask

    task automatic drain(input string req, input int pct, input int slot);
        int idle = 0;
        int pops = 0;
        int guard = 0;
        tx_enable = 1'b1; slot_sel = 2'(slot);
        while (idle < 10 && guard < 3000) begin
            @(negedge clk);
            guard++;
            pair_ready = (($urandom % 100) < pct);
            if (pair_valid) begin
                idle = 0;
                if (pair_ready) begin
                    if (q.size() < 2) begin
                        chk("R9", "pair with fewer than two queued", q.size(), 2);
                    end else begin
                        chk(req, "left", int'(pair_left), q[0]);
                        chk(req, "right", int'(pair_right), q[1]);
                        void'(q.pop_front()); void'(q.pop_front());
                    end
                    pops++;
                end
            end else begin
                idle++;
            end
        end
        @(negedge clk);
        tx_enable = 1'b0; pair_ready = 1'b0; slot_sel = 2'b00;
        if (slot == 0) chk("R8", "pairs with no slot", pops, 0);
        else chk("R8", "level below half after burst", int'(q.size() < D/2), 1);
        if (pops > 0) begin
            e_full = 0;
            if (q.size() <= D/2) e_half = 1;
            if (q.size() == 0) begin e_empty = 1; e_und = 1; end
        end
        @(negedge clk);
        check_flags(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed0;
        seed0 = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "pair_valid at reset", int'(pair_valid), 0);
        check_flags("R10");
        rst_n = 1'b1;
        @(negedge clk);
        check_flags("R10");

        // R1: every size code, with junk above each field
        do_write(32'hFFF00ABC, 3, 0, "R1");
        do_write(32'hFFFF1234, 0, 0, "R1");
        do_write(32'hFFF2ABCD, 1, 0, "R1");
        do_write(32'hFFF9876A, 2, 0, "R6");
        drain("R1", 100, 1);
        // R5: underrun set by full drain, cleared by a write
        chk("R5", "underrun after drain", int'(flag_underrun), 1);
        do_write(32'h00000111, 0, 0, "R5");
        // R8: below half level nothing is offered
        drain("R8", 100, 3);

        // R2 / R3: packed and ignored packed writes
        do_write(32'hBEEF1234, 0, 1, "R2");
        do_write(32'h0ABC0DEF, 3, 1, "R2");
        do_write(32'h0003FFFF, 1, 1, "R3");
        do_write(32'hFFFFFFFF, 2, 1, "R3");
        drain("R2", 100, 2);

        // R4 / R7: fill to full, extra writes dropped
        for (int i = 0; i < D; i++) do_write(32'h100 + i, 0, 0, "R7");
        chk("R7", "full set", int'(flag_full), 1);
        do_write(32'hDEAD, 0, 0, "R4");
        do_write(32'hBEEF, 0, 1, "R4");
        drain("R8", 100, 0);
        drain("R7", 100, 1);

        // R4: packed acceptance threshold level+2 < DEPTH
        for (int i = 0; i < D - 3; i++) do_write(32'h200 + i, 2, 0, "R4");
        do_write(32'h44443333, 0, 1, "R4");
        do_write(32'h66665555, 0, 1, "R4");
        do_write(32'h777, 2, 0, "R4");
        drain("R9", 50, 2);

        // Random mix
        for (int r = 0; r < 60; r++) begin
            int nw;
            nw = 1 + int'($urandom % 10);
            for (int w = 0; w < nw; w++) begin
                do_write($urandom, int'($urandom % 4), bit'($urandom % 2), "R6");
            end
            drain("R9", 30 + int'($urandom % 71), int'($urandom % 4));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule